// File: doc/BRIEF.md
# Phase-Frequency Comparator with Lock Detection

This block compares two single-cycle event strobes in the reference-clock domain: a reference event `fr_pls` and a divided-feedback event `fp_pls`. Whichever event comes first opens an error window. The window stays open until the other event arrives. The block turns that window into three things:

- drive requests for an external charge pump, as separate up, down and enable signals;
- two auxiliary comparator outputs: one push-pull, and one that is either pulled low or left floating;
- a single multiplexed output that carries either a lock flag or a monitor copy of one input.

The clock `clk` measures phase error in whole clock periods. Lock is lost as soon as an error window reaches a set length. Lock is regained only after a run of short comparisons in a row. The sense of the detector can be inverted with `fc_pol`, to suit the slope of the oscillator that the pump drives.

Two inputs take the pump drive away. `zc_n` low disables it. Power save (`ps_n` low) also disables it, clears the comparator and forces the lock flag high. When power save ends, the first error window drives the pump for at most one clock period, so the oscillator does not take a large step. Each completed comparison ends with a one-cycle pulse in which up and down are driven together. This pulse keeps the pump out of a dead zone when the loop is locked. The current-select bit is only passed through.

Top module: `pll_phase_cmp`

## Requirements
- R1: With `fc_pol`=1, a window opened by `fr_pls` gives `do_up`=1, `do_dn`=0 and `aux_p_low`=1, `aux_r`=0. A window opened by `fp_pls` gives `do_dn`=1, `do_up`=0 and `aux_r`=1, `aux_p_low`=0. `do_en`=1 in both cases. The window shows on the outputs in the same cycle that the strobe is captured.
- R2: With `fc_pol`=0 the sense is swapped. A window opened by `fr_pls` gives `do_dn`=1, `aux_r`=1, `aux_p_low`=0. A window opened by `fp_pls` gives `do_up`=1, `aux_p_low`=1, `aux_r`=0.
- R3: The capture that closes a comparison (the lagging strobe, or both strobes in one cycle) is followed by exactly one cycle with `do_up`=`do_dn`=`do_en`=1. After that, with no new strobe, `do_en`=0 and both auxiliary outputs are 0.
- R4: While `zc_n`=0, `do_en`=0 whatever the phase state.
- R5: While `ps_n`=0, `do_en`=0 and the lock flag reads 1. Strobes captured during power save leave no open window behind. The lock flag still reads 1 in the first cycle after power save ends.
- R6: The lock flag goes to 0 in the cycle in which the open window reaches UNLOCK_W (default 4) cycles, even if the lagging strobe has not yet arrived.
- R7: Reset clears the lock flag and the pump drive. The flag goes to 1 at the capture of the LOCK_RUN-th (default 3) consecutive comparison whose width is at most LOCK_W (default 2) cycles. A comparison whose width lies between LOCK_W and UNLOCK_W leaves the flag unchanged but restarts the run. The width is the number of cycles from the leading capture to the lagging capture; equal captures count as width 0.
- R8: After reset or power save, the first error window drives `do_en`=1 only in its first cycle. Later windows drive `do_en` for their full length.
- R9: With `lds_sel`=1, `mon_out` follows `fr_pls` when `fc_pol`=1 and `fp_pls` when `fc_pol`=0. With `lds_sel`=0, `mon_out` is the lock flag.
- R10: `cs_stat` equals `cs_hi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, also the unit of phase error |
| rst_n | input | 1 | Synchronous active-low reset |
| fr_pls | input | 1 | Reference event strobe |
| fp_pls | input | 1 | Divided-feedback event strobe |
| fc_pol | input | 1 | Detector polarity (1 = reference lead pumps up) |
| lds_sel | input | 1 | Output select: 1 = monitor copy, 0 = lock flag |
| ps_n | input | 1 | Active-low power save |
| zc_n | input | 1 | Active-low forced disable of pump drive |
| cs_hi | input | 1 | Charge-pump current select, passed through |
| do_up | output | 1 | Pump source request |
| do_dn | output | 1 | Pump sink request |
| do_en | output | 1 | Pump drive enable (0 = floating) |
| aux_r | output | 1 | Push-pull auxiliary comparator output |
| aux_p_low | output | 1 | Pull-low request of the auxiliary open-drain output |
| mon_out | output | 1 | Lock flag or monitor copy |
| cs_stat | output | 1 | Copy of `cs_hi` |

## Verification
A wrong window register shows up in the capture cycle itself, as a wrong polarity on `do_up`/`do_dn` or on the auxiliary outputs. It also shows up one cycle after the lagging capture, as a missing or extra overlap pulse. A wrong width counter or run counter can only be seen on `mon_out`. It shows there at the capture where the lock flag should drop (the fourth cycle of a long window) or rise (the third short comparison). The bench places a mid-range comparison inside the run, so a counter that does not restart is exposed. A clamp flag that never clears, or never sets, shows up in the second cycle of the window after power save: `do_en` must be 0 then, and must be 1 in the second cycle of the window that follows.

// File: rtl/pll_cmp_pkg.sv
// Shared types of the phase comparator.
// Assumes: a comparison is classified once per clock cycle.
package pll_cmp_pkg;

    // Outcome of a comparison in the current cycle.
    typedef enum logic [1:0] {
        CMP_NONE = 2'd0,   // no comparison closed and no long window
        CMP_GOOD = 2'd1,   // closed with width <= LOCK_W
        CMP_HOLD = 2'd2,   // closed with LOCK_W < width < UNLOCK_W
        CMP_BAD  = 2'd3    // window width reached UNLOCK_W
    } cmp_res_e;

endpackage

// File: rtl/pll_pfd_core.sv
// Phase-frequency detector core. Keeps the open error window (up or down),
// measures its width in clock cycles, and classifies each cycle for the lock
// detector. It also emits a one-cycle overlap flag after a comparison
// closes, and a clamp flag for the first window after reset or power save.
// Assumes: fr_pls and fp_pls are single-cycle strobes synchronous to clk.
module pll_pfd_core
    import pll_cmp_pkg::*;
#(
    parameter int UNLOCK_W = 4,
    parameter int LOCK_W   = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ps_n,
    input  logic     fr_pls,
    input  logic     fp_pls,
    output logic     up_q,
    output logic     dn_q,
    output logic     adz_q,
    output logic     clamp_cut,
    output cmp_res_e cmp_res
);
    localparam int CW = $clog2(UNLOCK_W + 2);
    localparam logic [CW-1:0] UNLOCK_V = CW'(UNLOCK_W);
    localparam logic [CW-1:0] LOCK_V   = CW'(LOCK_W);

    logic [CW-1:0] wid_q;
    logic [CW-1:0] err_w;
    logic          clamp_q;
    logic          active, up_set, dn_set, meet;

    // Combine the held window with this cycle's strobes and measure the error.
    always_comb begin
        active = up_q | dn_q;
        up_set = up_q | fr_pls;
        dn_set = dn_q | fp_pls;
        meet   = up_set & dn_set;
        err_w  = wid_q + CW'(active);
    end

    // Classify this cycle for the lock detector.
    always_comb begin
        if (!ps_n)
            cmp_res = CMP_NONE;
        else if (err_w >= UNLOCK_V)
            cmp_res = CMP_BAD;
        else if (meet)
            cmp_res = (err_w <= LOCK_V) ? CMP_GOOD : CMP_HOLD;
        else
            cmp_res = CMP_NONE;
    end

    // Window, width, overlap and clamp state.
    always_ff @(posedge clk) begin
        if (!rst_n || !ps_n) begin
            up_q    <= 1'b0;
            dn_q    <= 1'b0;
            adz_q   <= 1'b0;
            wid_q   <= '0;
            clamp_q <= 1'b1;
        end else begin
            up_q  <= up_set & ~meet;
            dn_q  <= dn_set & ~meet;
            adz_q <= meet;
            if (meet || !active)
                wid_q <= '0;
            else if (wid_q < UNLOCK_V)
                wid_q <= wid_q + 1'b1;
            if (meet)
                clamp_q <= 1'b0;
        end
    end

    // The clamped window may drive only in its first cycle.
    assign clamp_cut = clamp_q & (wid_q != '0);
endmodule

// File: rtl/pll_lock_det.sv
// Lock detector. Drops the lock flag on a long window. Raises it after
// LOCK_RUN short comparisons in a row. A mid-range comparison restarts the
// run. Power save holds the flag set.
// Assumes: cmp_res is one classification per cycle.
module pll_lock_det
    import pll_cmp_pkg::*;
#(
    parameter int LOCK_RUN = 3
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ps_n,
    input  cmp_res_e cmp_res,
    output logic     lock_q
);
    localparam int RW = $clog2(LOCK_RUN + 1);
    localparam logic [RW-1:0] LAST_V = RW'(LOCK_RUN - 1);

    logic [RW-1:0] run_q;

    // Track the run of short comparisons and the lock flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
            run_q  <= '0;
        end else if (!ps_n) begin
            lock_q <= 1'b1;
            run_q  <= '0;
        end else begin
            case (cmp_res)
                CMP_BAD: begin
                    lock_q <= 1'b0;
                    run_q  <= '0;
                end
                CMP_HOLD: run_q <= '0;
                CMP_GOOD: begin
                    if (run_q >= LAST_V)
                        lock_q <= 1'b1;
                    else
                        run_q <= run_q + 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pll_out_map.sv
// Output mapping. Applies the polarity bit to the pump and auxiliary
// outputs, gates the pump enable, and selects the lock flag or the monitor
// copy. Purely combinational.
// Assumes: up_q and dn_q are never set together.
module pll_out_map (
    input  logic fc_pol,
    input  logic lds_sel,
    input  logic ps_n,
    input  logic zc_n,
    input  logic fr_pls,
    input  logic fp_pls,
    input  logic up_q,
    input  logic dn_q,
    input  logic adz_q,
    input  logic clamp_cut,
    input  logic lock_q,
    output logic do_up,
    output logic do_dn,
    output logic do_en,
    output logic aux_r,
    output logic aux_p_low,
    output logic mon_out
);
    logic lock_vis;

    // Polarity-dependent drive, enable gating and output select.
    always_comb begin
        do_up     = fc_pol ? (up_q | adz_q) : (dn_q | adz_q);
        do_dn     = fc_pol ? (dn_q | adz_q) : (up_q | adz_q);
        do_en     = zc_n & ps_n & (up_q | dn_q | adz_q) & ~clamp_cut;
        aux_r     = fc_pol ? dn_q : up_q;
        aux_p_low = fc_pol ? up_q : dn_q;
        lock_vis  = ps_n ? lock_q : 1'b1;
        mon_out   = lds_sel ? (fc_pol ? fr_pls : fp_pls) : lock_vis;
    end
endmodule

// File: rtl/pll_phase_cmp.sv
// Top of the phase comparator with lock detection. Connects the detector
// core, the lock detector and the output mapping. Passes the current-select
// bit through.
// Assumes: all inputs are synchronous to clk.
module pll_phase_cmp
    import pll_cmp_pkg::*;
#(
    parameter int UNLOCK_W = 4,
    parameter int LOCK_W   = 2,
    parameter int LOCK_RUN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fr_pls,
    input  logic fp_pls,
    input  logic fc_pol,
    input  logic lds_sel,
    input  logic ps_n,
    input  logic zc_n,
    input  logic cs_hi,
    output logic do_up,
    output logic do_dn,
    output logic do_en,
    output logic aux_r,
    output logic aux_p_low,
    output logic mon_out,
    output logic cs_stat
);
    logic     up_q, dn_q, adz_q, clamp_cut, lock_q;
    cmp_res_e cmp_res;

    pll_pfd_core #(.UNLOCK_W(UNLOCK_W), .LOCK_W(LOCK_W)) core_i (
        .clk(clk), .rst_n(rst_n), .ps_n(ps_n),
        .fr_pls(fr_pls), .fp_pls(fp_pls),
        .up_q(up_q), .dn_q(dn_q), .adz_q(adz_q),
        .clamp_cut(clamp_cut), .cmp_res(cmp_res)
    );

    pll_lock_det #(.LOCK_RUN(LOCK_RUN)) lock_i (
        .clk(clk), .rst_n(rst_n), .ps_n(ps_n),
        .cmp_res(cmp_res), .lock_q(lock_q)
    );

    pll_out_map map_i (
        .fc_pol(fc_pol), .lds_sel(lds_sel), .ps_n(ps_n), .zc_n(zc_n),
        .fr_pls(fr_pls), .fp_pls(fp_pls),
        .up_q(up_q), .dn_q(dn_q), .adz_q(adz_q),
        .clamp_cut(clamp_cut), .lock_q(lock_q),
        .do_up(do_up), .do_dn(do_dn), .do_en(do_en),
        .aux_r(aux_r), .aux_p_low(aux_p_low), .mon_out(mon_out)
    );

    // Current select is status only.
    assign cs_stat = cs_hi;
endmodule

// File: rtl/pll_phase_cmp_chk.sv
// Port-level properties of the phase comparator, bound to the top.
module pll_phase_cmp_chk (
    input logic clk,
    input logic rst_n,
    input logic ps_n,
    input logic zc_n,
    input logic lds_sel,
    input logic do_up,
    input logic do_dn,
    input logic do_en,
    input logic aux_r,
    input logic aux_p_low,
    input logic mon_out
);
    // R4: forced disable removes the pump drive.
    p_zc_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !zc_n |-> !do_en);

    // R5: power save removes the drive and shows lock.
    p_ps_force_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ps_n && !lds_sel) |-> (mon_out && !do_en));

    // R5: lock still reads high in the first cycle after power save.
    p_ps_exit_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ps_n && !$past(ps_n) && !lds_sel && $past(rst_n)) |-> mon_out);

    // R1: the two auxiliary outputs are never active together.
    p_aux_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(aux_r && aux_p_low));

    // R3: an enabled drive always carries an up or down request.
    p_en_has_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
        do_en |-> (do_up || do_dn));
endmodule

bind pll_phase_cmp pll_phase_cmp_chk chk_i (.*);

// File: tb/pll_phase_cmp_tb_top.sv
// Scoreboard bench: the driver pushes expected masked output words, and the
// monitor pops and compares them after the matching clock edge.
module pll_phase_cmp_tb_top;
    localparam logic [6:0] M_UP  = 7'b1000000;
    localparam logic [6:0] M_DN  = 7'b0100000;
    localparam logic [6:0] M_EN  = 7'b0010000;
    localparam logic [6:0] M_AR  = 7'b0001000;
    localparam logic [6:0] M_AP  = 7'b0000100;
    localparam logic [6:0] M_MON = 7'b0000010;
    localparam logic [6:0] M_CS  = 7'b0000001;
    localparam logic [6:0] M_PH  = M_UP | M_DN | M_EN | M_AR | M_AP;

    typedef struct {
        int         cyc;
        logic [6:0] mask;
        logic [6:0] val;
        string      req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fr_pls = 1'b0, fp_pls = 1'b0;
    logic fc_pol = 1'b1, lds_sel = 1'b0, ps_n = 1'b1, zc_n = 1'b1, cs_hi = 1'b0;
    logic do_up, do_dn, do_en, aux_r, aux_p_low, mon_out, cs_stat;

    logic cfg_rst = 1'b0, cfg_fc = 1'b1, cfg_lds = 1'b0;
    logic cfg_ps = 1'b1, cfg_zc = 1'b1, cfg_cs = 1'b0;

    exp_t q[$];
    int   cyc = 0;
    int   tgt = 0;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    pll_phase_cmp dut_i (
        .clk(clk), .rst_n(rst_n), .fr_pls(fr_pls), .fp_pls(fp_pls),
        .fc_pol(fc_pol), .lds_sel(lds_sel), .ps_n(ps_n), .zc_n(zc_n),
        .cs_hi(cs_hi), .do_up(do_up), .do_dn(do_dn), .do_en(do_en),
        .aux_r(aux_r), .aux_p_low(aux_p_low), .mon_out(mon_out),
        .cs_stat(cs_stat)
    );

    // Apply one cycle of stimulus at the falling edge.
    task automatic step(input logic f_r, input logic f_p);
        @(negedge clk);
        rst_n   = cfg_rst;
        fc_pol  = cfg_fc;
        lds_sel = cfg_lds;
        ps_n    = cfg_ps;
        zc_n    = cfg_zc;
        cs_hi   = cfg_cs;
        fr_pls  = f_r;
        fp_pls  = f_p;
        tgt     = cyc + 1;
    endtask

    // Expect masked outputs after the edge that captures the last step.
    task automatic chk(input logic [6:0] mask, input logic [6:0] val, input string req);
        exp_t it;
        it.cyc  = tgt;
        it.mask = mask;
        it.val  = val & mask;
        it.req  = req;
        q.push_back(it);
    endtask

    // Monitor: sample just after each rising edge and compare.
    initial begin
        forever begin
            logic [6:0] obs;
            @(posedge clk);
            cyc++;
            #1;
            obs = {do_up, do_dn, do_en, aux_r, aux_p_low, mon_out, cs_stat};
            while (q.size() > 0 && q[0].cyc <= cyc) begin
                exp_t it;
                it = q.pop_front();
                n_chk++;
                if (it.cyc != cyc || (obs & it.mask) != it.val) begin
                    n_bad++;
                    $display("FAIL %s cycle %0d: actual %b expected %b (mask %b)",
                             it.req, cyc, obs & it.mask, it.val, it.mask);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #100000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog (all requirements): actual hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // Reset state (R7).
        step(0, 0); chk(M_EN | M_MON, 7'b0, "R7");
        step(0, 0); chk(M_EN | M_MON, 7'b0, "R7");
        // Power save (R5).
        cfg_rst = 1'b1; cfg_ps = 1'b0;
        step(0, 0); chk(M_EN | M_MON, M_MON, "R5");
        step(1, 0); chk(M_EN | M_MON, M_MON, "R5");
        step(0, 1); chk(M_EN | M_MON, M_MON, "R5");
        cfg_ps = 1'b1;
        step(0, 0); chk(M_EN | M_MON, M_MON, "R5");
        // First window after power save is clamped (R8), width 3 holds lock (R7).
        step(1, 0); chk(M_UP | M_DN | M_EN, M_UP | M_EN, "R8");
        step(0, 0); chk(M_EN, 7'b0, "R8");
        step(0, 0); chk(M_EN, 7'b0, "R8");
        step(0, 1); chk(M_UP | M_DN | M_EN, M_UP | M_DN | M_EN, "R3");
        step(0, 0); chk(M_EN | M_MON, M_MON, "R7");
        // Reference lead, fc=1 (R1); clamp released (R8).
        step(1, 0); chk(M_PH, M_UP | M_EN | M_AP, "R1");
        step(0, 0); chk(M_UP | M_EN, M_UP | M_EN, "R8");
        step(0, 1); chk(M_UP | M_DN | M_EN, M_UP | M_DN | M_EN, "R3");
        step(0, 0); chk(M_EN | M_AR | M_AP, 7'b0, "R3");
        // Reference lag, fc=1 (R1).
        step(0, 1); chk(M_PH, M_DN | M_EN | M_AR, "R1");
        step(1, 0); chk(M_UP | M_DN | M_EN, M_UP | M_DN | M_EN, "R3");
        step(0, 0); chk(M_EN, 7'b0, "R3");
        // Inverted polarity (R2).
        cfg_fc = 1'b0;
        step(1, 0); chk(M_UP | M_DN | M_AR | M_AP, M_DN | M_AR, "R2");
        step(0, 1);
        step(0, 0);
        step(0, 1); chk(M_UP | M_DN | M_AR | M_AP, M_UP | M_AP, "R2");
        step(1, 0);
        step(0, 0);
        cfg_fc = 1'b1;
        // Forced disable (R4).
        cfg_zc = 1'b0;
        step(1, 0); chk(M_EN, 7'b0, "R4");
        step(0, 1); chk(M_EN, 7'b0, "R4");
        cfg_zc = 1'b1;
        step(0, 0);
        // Long window drops lock at width 4 (R6).
        step(1, 0);
        step(0, 0);
        step(0, 0);
        step(0, 0); chk(M_MON, M_MON, "R6");
        step(0, 0); chk(M_MON, 7'b0, "R6");
        step(0, 1);
        step(0, 0);
        // Lock rise after three short comparisons, restarted by width 3 (R7).
        step(1, 1); chk(M_UP | M_DN | M_EN | M_MON, M_UP | M_DN | M_EN, "R3");
        step(0, 0); chk(M_EN, 7'b0, "R3");
        step(1, 1);
        step(0, 0);
        step(1, 0);
        step(0, 0);
        step(0, 0);
        step(0, 1); chk(M_MON, 7'b0, "R7");
        step(0, 0);
        step(1, 1);
        step(0, 0);
        step(1, 1); chk(M_MON, 7'b0, "R7");
        step(0, 0);
        step(1, 1); chk(M_MON, M_MON, "R7");
        step(0, 0);
        // Monitor select (R9).
        cfg_lds = 1'b1;
        step(1, 0); chk(M_MON, M_MON, "R9");
        step(0, 1); chk(M_MON, 7'b0, "R9");
        cfg_fc = 1'b0;
        step(0, 1); chk(M_MON, M_MON, "R9");
        step(1, 0); chk(M_MON, 7'b0, "R9");
        step(0, 0);
        cfg_lds = 1'b0; cfg_fc = 1'b1;
        step(0, 0); chk(M_MON, M_MON, "R9");
        // Power save forces lock high from a lost state (R5).
        step(1, 0);
        step(0, 0);
        step(0, 0);
        step(0, 0);
        step(0, 0); chk(M_MON, 7'b0, "R6");
        cfg_ps = 1'b0;
        step(0, 0); chk(M_EN | M_MON, M_MON, "R5");
        cfg_ps = 1'b1;
        step(0, 0); chk(M_EN | M_MON, M_MON, "R5");
        // Current select pass-through (R10).
        cfg_cs = 1'b1;
        step(0, 0); chk(M_CS, M_CS, "R10");
        cfg_cs = 1'b0;
        step(0, 0); chk(M_CS, 7'b0, "R10");
        repeat (3) step(0, 0);
        @(posedge clk);
        #2;
        n_bad += q.size();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule